// File: doc/BRIEF.md
# Regulator Voltage Programming and Status Poll Sequencer

This block sits on the management side of a chip and sets the core supply through one or more external voltage regulators on a PMBus segment. A program request takes a target voltage and encodes it once into a 16-bit output-voltage word. The encoding is either an integer shifted by a signed exponent or a scaled value of the form slope times value plus offset, times a power of ten. The block then walks the regulators from index 0 upward. For each one it can first write a page selector, and then it writes the output-voltage command. Every bus action is handed to a downstream byte engine over a request/acknowledge handshake: start, one written byte, one read byte, or stop.

Once programming is complete, the block can poll each regulator's one-byte status at a fixed period that is derived from a clock-frequency parameter. A non-zero status byte lights a per-regulator alert. A refused byte (NACK) ends that regulator's transaction early and sets a sticky per-regulator fault. A zero address for regulator 0 is a configuration error: the block keeps the bus silent. Bit-level I2C timing is left entirely to the byte engine. The block only passes the selected bus rate to the engine as one mode bit.

Top module: `pvs_vid_seq`

## Requirements
- R1: The number of regulators is `reg_last`+1 (1 to 8). Regulators are served in index order from 0. Regulator i uses the 7-bit address in `reg_addr[7i+6:7i]`. Its write address byte is {addr,0} and its read address byte is {addr,1}.
- R2: When a program request arrives and the address of regulator 0 is zero, the block sets `cfg_err` and `vid_error`, leaves `prog_done` low, and issues no bus operation. The next program request that has a valid address clears `cfg_err`.
- R3: With `page_en` high, each regulator first receives the sequence start, address-write, 0x00, `page_sel`, stop. With `page_en` low, no page transaction is sent.
- R4: Each regulator's voltage transaction is start, address-write, 0x21, low byte of the voltage word, high byte, stop. Operation codes on `eng_op` are 0 start, 1 write, 2 read, 3 stop. `eng_wdata` is 0 for operations other than write.
- R5: In shift format, the 5-bit two's-complement exponent N gives word = X·2^(−N) (a left shift for negative N, a truncating right shift otherwise), saturated to 65535.
- R6: In scaled format, word = (m·X + b)·10^R, where m and b are signed 16-bit values and R is a signed 8-bit value clamped to −3..3. Division rounds half away from zero. The result is saturated to the signed 16-bit range and sent as two's complement.
- R7: With `unit_volts` low, X is `tgt_mv`. With `unit_volts` high, X is `tgt_mv`/1000 rounded half up.
- R8: After a successful program and with `poll_en` high, a poll round starts exactly every POLL_CYCLES clock cycles. A round sends start, address-write, 0x78, start, address-read, read, stop to each regulator. With `poll_en` low, no round starts.
- R9: In a poll round, a non-zero status byte sets `stat_alert[i]` and `vid_error`. A zero status byte clears `stat_alert[i]`.
- R10: A NACK on a written byte makes the block skip to that transaction sequence's final stop and set `nack_fault[i]`. The block then continues with the next regulator. The fault bits stay set until the next program request.
- R11: `eng_fast` follows `fast_mode` (0 = 100 kHz, 1 = 400 kHz).
- R12: While `eng_req` is high and `eng_ack` is low, `eng_op` and `eng_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Start programming (taken while idle) |
| tgt_mv | input | 16 | Target voltage in millivolts |
| unit_volts | input | 1 | Encode the target in volts instead of millivolts |
| reg_last | input | 3 | Index of the last regulator |
| reg_addr | input | 56 | Packed 7-bit regulator addresses |
| fmt_direct | input | 1 | 1 = scaled format, 0 = shift format |
| lin_exp | input | 5 | Shift-format exponent N |
| coef_m | input | 16 | Scaled-format slope |
| coef_b | input | 16 | Scaled-format offset |
| coef_r | input | 8 | Scaled-format decimal exponent |
| page_en | input | 1 | Send a page write before each voltage write |
| page_sel | input | 8 | Page value (0xFF = all channels) |
| poll_en | input | 1 | Enable periodic status polling |
| fast_mode | input | 1 | Bus rate selection |
| eng_req | output | 1 | Byte-engine request |
| eng_op | output | 2 | Byte-engine operation |
| eng_wdata | output | 8 | Byte to write |
| eng_ack | input | 1 | Operation complete |
| eng_nack | input | 1 | Written byte refused (valid with ack) |
| eng_rdata | input | 8 | Byte read (valid with ack) |
| eng_fast | output | 1 | Bus rate to the byte engine |
| busy | output | 1 | A sequence is in progress |
| prog_done | output | 1 | Last program completed |
| cfg_err | output | 1 | Configuration error |
| nack_fault | output | 8 | Sticky per-regulator NACK faults |
| stat_alert | output | 8 | Per-regulator non-zero status |
| vid_error | output | 1 | Any error or alert |

## Verification
The bench sweeps the shift exponent over all 32 values. A design that shifts the wrong way, or that wraps instead of saturating, produces wrong low or high voltage bytes. It sweeps the decimal exponent past both ends of its clamp, with negative products. A design that truncates rather than rounding away from zero, or that lets R = ±4 through, is off by one or saturates wrongly. It refuses an address byte in the middle of a page-enabled chain, which catches a design that stalls, sends the orphaned command bytes, or drops the later regulators. It also measures the cycle distance between poll rounds and checks that a zero address for regulator 0 leaves the bus silent.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_WRITE = 2'd1,
    BOP_READ  = 2'd2,
    BOP_STOP  = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PROG = 2'd1,
    SQ_POLL = 2'd2
  } sq_e;

  localparam int          VOUT_W    = 16;
  localparam logic [7:0]  CMD_PAGE  = 8'h00;
  localparam logic [7:0]  CMD_VOUT  = 8'h21;
  localparam logic [7:0]  CMD_STAT  = 8'h78;

  // micro-step positions inside the per-regulator sequences
  localparam logic [3:0]  STP_PAGE0 = 4'd0;
  localparam logic [3:0]  STP_VOUT0 = 4'd5;
  localparam logic [3:0]  STP_PLAST = 4'd10;
  localparam logic [3:0]  STP_QLAST = 4'd6;
endpackage

// File: rtl/pvs_vout_enc.sv
module pvs_vout_enc
  import pvs_pkg::*;
(
  input  logic [VOUT_W-1:0] mv,
  input  logic              unit_volts,
  input  logic              fmt_direct,
  input  logic [4:0]        lin_exp,
  input  logic [15:0]       coef_m,
  input  logic [15:0]       coef_b,
  input  logic [7:0]        coef_r,
  output logic [VOUT_W-1:0] vout
);
  localparam int PW = 48;

  logic [VOUT_W:0]         xv;
  logic [VOUT_W-1:0]       x;
  logic signed [5:0]       ne;
  logic [5:0]              sh;
  logic [2*VOUT_W-1:0]     lin_w;
  logic [VOUT_W-1:0]       lin_v;
  logic signed [PW-1:0]    prod, mag, fac, q, scl;
  logic signed [7:0]       rc;
  logic                    rdiv;
  logic [VOUT_W-1:0]       dir_v;

  always_comb begin
    // unit translation
    xv = ({1'b0, mv} + 17'd500) / 17'd1000;
    x  = unit_volts ? xv[VOUT_W-1:0] : mv;

    // shift format
    ne = signed'({lin_exp[4], lin_exp});
    if (ne < 0) begin
      sh    = 6'(-ne);
      lin_w = {16'd0, x} << sh;
    end else begin
      sh    = 6'(ne);
      lin_w = {16'd0, x} >> sh;
    end
    lin_v = (|lin_w[2*VOUT_W-1:VOUT_W]) ? 16'hFFFF : lin_w[VOUT_W-1:0];

    // scaled format
    prod = signed'({{(PW-16){coef_m[15]}}, coef_m}) * signed'({{(PW-16){1'b0}}, x})
         + signed'({{(PW-16){coef_b[15]}}, coef_b});
    rc = signed'(coef_r);
    if (rc > 8'sd3)       rc = 8'sd3;
    else if (rc < -8'sd3) rc = -8'sd3;
    rdiv = rc[7];
    case (rc)
      8'sd3, -8'sd3: fac = 48'sd1000;
      8'sd2, -8'sd2: fac = 48'sd100;
      8'sd1, -8'sd1: fac = 48'sd10;
      default:       fac = 48'sd1;
    endcase
    mag = prod[PW-1] ? -prod : prod;
    q   = (mag + (fac >>> 1)) / fac;
    if (rdiv) scl = prod[PW-1] ? -q : q;
    else      scl = prod * fac;
    if (scl > 48'sd32767)       dir_v = 16'h7FFF;
    else if (scl < -48'sd32768) dir_v = 16'h8000;
    else                        dir_v = scl[VOUT_W-1:0];

    vout = fmt_direct ? dir_v : lin_v;
  end
endmodule

// File: rtl/pvs_tick.sv
module pvs_tick #(
  parameter int CYC = 50_000_000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int            CW   = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    if (!run)        cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
    tick = run & at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  generate
    if (CYC > 1) begin : g_spacing
      assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pvs_vid_seq.sv
module pvs_vid_seq
  import pvs_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int POLL_CYCLES = CLK_HZ / 2,
  parameter int NREG        = 8,
  parameter int AW          = 7
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_req,
  input  logic [15:0]               tgt_mv,
  input  logic                      unit_volts,
  input  logic [$clog2(NREG)-1:0]   reg_last,
  input  logic [NREG*AW-1:0]        reg_addr,
  input  logic                      fmt_direct,
  input  logic [4:0]                lin_exp,
  input  logic [15:0]               coef_m,
  input  logic [15:0]               coef_b,
  input  logic [7:0]                coef_r,
  input  logic                      page_en,
  input  logic [7:0]                page_sel,
  input  logic                      poll_en,
  input  logic                      fast_mode,
  output logic                      eng_req,
  output logic [1:0]                eng_op,
  output logic [7:0]                eng_wdata,
  input  logic                      eng_ack,
  input  logic                      eng_nack,
  input  logic [7:0]                eng_rdata,
  output logic                      eng_fast,
  output logic                      busy,
  output logic                      prog_done,
  output logic                      cfg_err,
  output logic [NREG-1:0]           nack_fault,
  output logic [NREG-1:0]           stat_alert,
  output logic                      vid_error
);
  localparam int IW = $clog2(NREG);

  sq_e               state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [3:0]        step_q, step_d;
  logic [VOUT_W-1:0] vout_q, vout_d;
  logic [NREG-1:0]   fault_q, fault_d;
  logic [NREG-1:0]   alert_q, alert_d;
  logic              cfg_q, cfg_d;
  logic              armed_q, armed_d;
  logic              pend_q, pend_d;

  logic [VOUT_W-1:0] enc_word;
  logic              tick;
  logic [AW-1:0]     cur_addr;
  logic [3:0]        first_c, last_c;
  logic              prog_go, poll_go;
  bop_e              op_c;
  logic [7:0]        wd_c;

  pvs_vout_enc u_enc (
    .mv(tgt_mv), .unit_volts(unit_volts), .fmt_direct(fmt_direct),
    .lin_exp(lin_exp), .coef_m(coef_m), .coef_b(coef_b), .coef_r(coef_r),
    .vout(enc_word)
  );

  pvs_tick #(.CYC(POLL_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(armed_q & poll_en), .tick(tick)
  );

  // current byte operation from the sequence step
  always_comb begin
    cur_addr = reg_addr[idx_q*AW +: AW];
    op_c     = BOP_STOP;
    wd_c     = 8'h00;
    if (state_q == SQ_PROG) begin
      case (step_q)
        4'd0, 4'd5: op_c = BOP_START;
        4'd1, 4'd6: begin op_c = BOP_WRITE; wd_c = {cur_addr, 1'b0}; end
        4'd2:       begin op_c = BOP_WRITE; wd_c = CMD_PAGE; end
        4'd3:       begin op_c = BOP_WRITE; wd_c = page_sel; end
        4'd7:       begin op_c = BOP_WRITE; wd_c = CMD_VOUT; end
        4'd8:       begin op_c = BOP_WRITE; wd_c = vout_q[7:0]; end
        4'd9:       begin op_c = BOP_WRITE; wd_c = vout_q[15:8]; end
        default:    op_c = BOP_STOP;
      endcase
    end else if (state_q == SQ_POLL) begin
      case (step_q)
        4'd0, 4'd3: op_c = BOP_START;
        4'd1:       begin op_c = BOP_WRITE; wd_c = {cur_addr, 1'b0}; end
        4'd2:       begin op_c = BOP_WRITE; wd_c = CMD_STAT; end
        4'd4:       begin op_c = BOP_WRITE; wd_c = {cur_addr, 1'b1}; end
        4'd5:       op_c = BOP_READ;
        default:    op_c = BOP_STOP;
      endcase
    end
  end

  // next-state logic
  always_comb begin
    state_d = state_q;  idx_d   = idx_q;   step_d = step_q;
    vout_d  = vout_q;   fault_d = fault_q; alert_d = alert_q;
    cfg_d   = cfg_q;    armed_d = armed_q; pend_d = pend_q;

    first_c = page_en ? STP_PAGE0 : STP_VOUT0;
    last_c  = (state_q == SQ_PROG) ? STP_PLAST : STP_QLAST;
    prog_go = (state_q == SQ_IDLE) & prog_req;
    poll_go = (state_q == SQ_IDLE) & ~prog_req & pend_q & armed_q & poll_en;

    if (prog_go) begin
      fault_d = '0;
      alert_d = '0;
      armed_d = 1'b0;
      idx_d   = '0;
      if (reg_addr[AW-1:0] == '0) begin
        cfg_d = 1'b1;
      end else begin
        cfg_d   = 1'b0;
        vout_d  = enc_word;
        step_d  = first_c;
        state_d = SQ_PROG;
      end
    end else if (poll_go) begin
      pend_d  = 1'b0;
      idx_d   = '0;
      step_d  = '0;
      state_d = SQ_POLL;
    end else if (state_q != SQ_IDLE && eng_ack) begin
      if (eng_nack && op_c == BOP_WRITE) begin
        fault_d[idx_q] = 1'b1;
        step_d         = last_c;
      end else if (step_q == last_c) begin
        if (idx_q == reg_last) begin
          state_d = SQ_IDLE;
          if (state_q == SQ_PROG) armed_d = 1'b1;
        end else begin
          idx_d  = idx_q + 1'b1;
          step_d = (state_q == SQ_PROG) ? first_c : 4'd0;
        end
      end else begin
        if (op_c == BOP_READ) alert_d[idx_q] = |eng_rdata;
        step_d = step_q + 4'd1;
      end
    end

    if (tick) pend_d = 1'b1;
    if (!armed_q || !poll_en) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE; idx_q   <= '0; step_q  <= '0; vout_q <= '0;
      fault_q <= '0;      alert_q <= '0; cfg_q   <= 1'b0;
      armed_q <= 1'b0;    pend_q  <= 1'b0;
    end else begin
      state_q <= state_d; idx_q   <= idx_d;   step_q  <= step_d; vout_q <= vout_d;
      fault_q <= fault_d; alert_q <= alert_d; cfg_q   <= cfg_d;
      armed_q <= armed_d; pend_q  <= pend_d;
    end
  end

  assign eng_req    = (state_q != SQ_IDLE);
  assign eng_op     = op_c;
  assign eng_wdata  = wd_c;
  assign eng_fast   = fast_mode;
  assign busy       = eng_req;
  assign prog_done  = armed_q;
  assign cfg_err    = cfg_q;
  assign nack_fault = fault_q;
  assign stat_alert = alert_q;
  assign vid_error  = cfg_q | (|fault_q) | (|alert_q);

  assert_cfg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !eng_req);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_go |=> ((nack_fault & $past(nack_fault)) == $past(nack_fault)));

  assert_poll_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_POLL) |-> prog_done);
endmodule

// File: tb/test_pvs_vid_seq.sv
module test_pvs_vid_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLLC      = 64;
  localparam logic [1:0] OS = 2'd0, OW = 2'd1, OR = 2'd2, OP = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        prog_req = 1'b0;
  logic [15:0] tgt_mv = 16'd850;
  logic        unit_volts = 1'b0;
  logic [2:0]  reg_last = 3'd0;
  logic [55:0] reg_addr;
  logic        fmt_direct = 1'b0;
  logic [4:0]  lin_exp = 5'd0;
  logic [15:0] coef_m = 16'd1, coef_b = 16'd0;
  logic [7:0]  coef_r = 8'd0;
  logic        page_en = 1'b0;
  logic [7:0]  page_sel = 8'hFF;
  logic        poll_en = 1'b0, fast_mode = 1'b0;
  logic        eng_req, eng_fast, busy, prog_done, cfg_err, vid_error;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wdata;
  logic        eng_ack = 1'b0, eng_nack = 1'b0;
  logic [7:0]  eng_rdata = 8'h00;
  logic [7:0]  nack_fault, stat_alert;

  logic [6:0]  addr_tab [0:7];
  logic [7:0]  stat_tab [0:7];
  always_comb for (int i = 0; i < 8; i++) reg_addr[i*7 +: 7] = addr_tab[i];

  pvs_vid_seq #(.POLL_CYCLES(POLLC)) i_pvs_vid_seq (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .tgt_mv(tgt_mv),
    .unit_volts(unit_volts), .reg_last(reg_last), .reg_addr(reg_addr),
    .fmt_direct(fmt_direct), .lin_exp(lin_exp), .coef_m(coef_m),
    .coef_b(coef_b), .coef_r(coef_r), .page_en(page_en), .page_sel(page_sel),
    .poll_en(poll_en), .fast_mode(fast_mode), .eng_req(eng_req),
    .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
    .eng_nack(eng_nack), .eng_rdata(eng_rdata), .eng_fast(eng_fast),
    .busy(busy), .prog_done(prog_done), .cfg_err(cfg_err),
    .nack_fault(nack_fault), .stat_alert(stat_alert), .vid_error(vid_error)
  );

  int checks = 0, bad = 0;
  logic [9:0] log_q [0:511];
  logic [9:0] exp_q [0:511];
  int nlog = 0, nexp = 0;
  int ack_delay = 0, hold = 0, hold_bad = 0;
  logic [1:0] f_op; logic [7:0] f_wd;
  logic addr_next = 1'b0; logic [6:0] cur_a = '0; logic [6:0] nack_addr = '0;
  int cyc = 0, nr = 0; int rstart [0:15]; logic req_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // byte-engine model
  always @(negedge clk) begin
    if (eng_req && !req_prev && nr < 16) begin rstart[nr] = cyc; nr++; end
    req_prev = eng_req;
    if (eng_ack) begin
      eng_ack = 1'b0; eng_nack = 1'b0; hold = 0;
    end else if (eng_req) begin
      if (hold == 0) begin f_op = eng_op; f_wd = eng_wdata; end
      else if (eng_op != f_op || eng_wdata != f_wd) hold_bad++;
      if (hold >= ack_delay) begin
        if (nlog < 512) begin log_q[nlog] = {eng_op, eng_wdata}; nlog++; end
        eng_nack = 1'b0;
        if (eng_op == OS) addr_next = 1'b1;
        else if (eng_op == OW && addr_next) begin
          addr_next = 1'b0; cur_a = eng_wdata[7:1];
          eng_nack = (nack_addr != 0) && (eng_wdata[7:1] == nack_addr);
        end else if (eng_op == OR) eng_rdata = stat_tab[cur_a[2:0]];
        eng_ack = 1'b1;
      end else hold++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint ex);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, ex);
    end
  endtask

  task automatic ex(input logic [1:0] op, input logic [7:0] d);
    exp_q[nexp] = {op, d}; nexp++;
  endtask

  task automatic chk_log(input string rq, input string what);
    int at = -1;
    if (nlog == nexp)
      for (int i = nexp - 1; i >= 0; i--) if (log_q[i] != exp_q[i]) at = i;
    if (nlog != nexp) chk(0, rq, {what, " op count"}, nlog, nexp);
    else if (at >= 0) chk(0, rq, {what, " op mismatch"}, log_q[at], exp_q[at]);
    else chk(1, rq, what, 0, 0);
  endtask

  function automatic longint bx(input int mv, input bit uv);
    return uv ? (mv + 500) / 1000 : mv;
  endfunction

  function automatic int e_lin(input longint x, input int n);
    longint v = (n < 0) ? (x << (-n)) : (x >> n);
    return (v > 65535) ? 65535 : int'(v);
  endfunction

  function automatic int e_dir(input longint x, input int m, input int b, input int r);
    longint p = m * x + b, y, d, a;
    int rr = (r > 3) ? 3 : ((r < -3) ? -3 : r);
    if (rr >= 0) y = p * (10 ** rr);
    else begin
      d = 10 ** (-rr); a = (p < 0) ? -p : p;
      y = (a + d / 2) / d; if (p < 0) y = -y;
    end
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y) & 16'hFFFF;
  endfunction

  task automatic ex_prog(input logic [6:0] a, input bit pe, input logic [7:0] pg,
                         input int v, input bit nk);
    if (nk) begin ex(OS, 0); ex(OW, {a, 1'b0}); ex(OP, 0); return; end
    if (pe) begin ex(OS, 0); ex(OW, {a, 1'b0}); ex(OW, 8'h00); ex(OW, pg); ex(OP, 0); end
    ex(OS, 0); ex(OW, {a, 1'b0}); ex(OW, 8'h21);
    ex(OW, v[7:0]); ex(OW, v[15:8]); ex(OP, 0);
  endtask

  task automatic ex_poll(input logic [6:0] a);
    ex(OS, 0); ex(OW, {a, 1'b0}); ex(OW, 8'h78); ex(OS, 0);
    ex(OW, {a, 1'b1}); ex(OR, 0); ex(OP, 0);
  endtask

  task automatic do_prog();
    @(negedge clk); nlog = 0; nexp = 0; prog_req = 1'b1;
    @(negedge clk); prog_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic wait_round();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL R8 watchdog: actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int v;
    int mvs [0:3] = '{850, 1000, 3, 65535};
    int ms [0:3] = '{1, -3, 200, 32767};
    int bs [0:2] = '{0, -1, 500};
    int xs [0:2] = '{850, 0, 1200};
    for (int i = 0; i < 8; i++) begin addr_tab[i] = 7'h10 + 7'(i); stat_tab[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R10)
    chk(eng_req == 0 && prog_done == 0, "R1", "reset idle", eng_req, 0);
    chk(nack_fault == 0 && vid_error == 0 && cfg_err == 0, "R10", "reset flags", nack_fault, 0);

    // R11: bus rate pass-through
    fast_mode = 1'b1; #1 chk(eng_fast == 1, "R11", "fast", eng_fast, 1);
    fast_mode = 1'b0; #1 chk(eng_fast == 0, "R11", "slow", eng_fast, 0);

    // R5: shift format sweep of every exponent
    for (int n = -16; n <= 15; n++)
      for (int k = 0; k < 4; k++) begin
        lin_exp = 5'(n); tgt_mv = 16'(mvs[k]);
        do_prog();
        ex_prog(addr_tab[0], 0, 0, e_lin(bx(mvs[k], 0), n), 0);
        chk_log("R5", $sformatf("shift n=%0d mv=%0d", n, mvs[k]));
      end

    // R7: volts unit with N=0
    lin_exp = 5'd0; unit_volts = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tgt_mv = 16'(k == 0 ? 1499 : (k == 1 ? 1500 : mvs[k + 1 - 1 + (k == 2 ? -2 : 0)]));
      v = tgt_mv;
      do_prog();
      ex_prog(addr_tab[0], 0, 0, e_lin(bx(v, 1), 0), 0);
      chk_log("R7", $sformatf("volts mv=%0d", v));
    end
    unit_volts = 1'b0;

    // R6: scaled format, R swept past the clamp on both sides
    fmt_direct = 1'b1;
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 3; c++)
        for (int k = 0; k < 3; k++)
          for (int r = -4; r <= 4; r++) begin
            coef_m = 16'(ms[a]); coef_b = 16'(bs[c]); coef_r = 8'(r); tgt_mv = 16'(xs[k]);
            do_prog();
            ex_prog(addr_tab[0], 0, 0, e_dir(xs[k], ms[a], bs[c], r), 0);
            chk_log("R6", $sformatf("scaled m=%0d b=%0d x=%0d r=%0d", ms[a], bs[c], xs[k], r));
          end
    coef_m = 16'd1; coef_b = 16'd0; coef_r = 8'd0; tgt_mv = 16'd850;
    v = e_dir(850, 1, 0, 0);

    // R1, R3, R4: every regulator count, page on/off, with slow acks (R12)
    ack_delay = 2;
    for (int n = 0; n < 8; n++)
      for (int pe = 0; pe < 2; pe++) begin
        reg_last = 3'(n); page_en = pe[0]; page_sel = (n[0]) ? 8'h05 : 8'hFF;
        do_prog();
        for (int i = 0; i <= n; i++) ex_prog(addr_tab[i], pe[0], page_sel, v, 0);
        chk_log(pe ? "R3" : "R4", $sformatf("chain last=%0d page=%0d", n, pe));
        chk(prog_done == 1, "R1", "done after chain", prog_done, 1);
      end
    ack_delay = 0;

    // R10: refused address mid-chain with paging
    reg_last = 3'd2; page_en = 1'b1; page_sel = 8'hFF; nack_addr = addr_tab[1];
    do_prog();
    for (int i = 0; i < 3; i++) ex_prog(addr_tab[i], 1, 8'hFF, v, i == 1);
    chk_log("R10", "nack chain");
    chk(nack_fault == 8'h02, "R10", "fault bit", nack_fault, 2);
    chk(vid_error == 1, "R10", "error line", vid_error, 1);
    repeat (40) @(negedge clk);
    chk(nack_fault == 8'h02, "R10", "fault sticky", nack_fault, 2);
    nack_addr = addr_tab[0]; page_en = 1'b0; reg_last = 3'd1;
    do_prog();
    ex_prog(addr_tab[0], 0, 0, v, 1); ex_prog(addr_tab[1], 0, 0, v, 0);
    chk_log("R10", "nack first no page");
    chk(nack_fault == 8'h01, "R10", "fault replaced", nack_fault, 1);
    nack_addr = '0;
    do_prog();
    chk(nack_fault == 0 && vid_error == 0, "R10", "cleared by program", nack_fault, 0);

    // R2: zero address for regulator 0
    addr_tab[0] = 7'h00;
    do_prog();
    repeat (20) @(negedge clk);
    chk(nlog == 0, "R2", "bus silent", nlog, 0);
    chk(cfg_err == 1 && vid_error == 1, "R2", "cfg flag", cfg_err, 1);
    chk(prog_done == 0, "R2", "not done", prog_done, 0);
    addr_tab[0] = 7'h10;
    do_prog();
    chk(cfg_err == 0 && prog_done == 1, "R2", "recovered", cfg_err, 0);

    // R8, R9: periodic polling
    reg_last = 3'd1; stat_tab[1] = 8'h40; poll_en = 1'b1;
    do_prog();
    nlog = 0; nexp = 0; nr = 0;
    wait_round();
    ex_poll(addr_tab[0]); ex_poll(addr_tab[1]);
    chk_log("R8", "poll round");
    chk(stat_alert == 8'h02, "R9", "alert bit", stat_alert, 2);
    chk(vid_error == 1, "R9", "alert error", vid_error, 1);
    stat_tab[1] = 8'h00;
    wait_round();
    chk(nr >= 2 && rstart[1] - rstart[0] == POLLC, "R8", "round spacing",
        rstart[1] - rstart[0], POLLC);
    chk(stat_alert == 0 && vid_error == 0, "R9", "alert cleared", stat_alert, 0);
    poll_en = 1'b0; nlog = 0;
    repeat (3 * POLLC) @(negedge clk);
    chk(nlog == 0, "R8", "no poll when disabled", nlog, 0);

    chk(hold_bad == 0, "R12", "request held until ack", hold_bad, 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule